// File: doc/BRIEF.md
# Line Buffer Memory Configuration Search

This unit chooses how the shared line-buffer memory of a display scaler is split. It compares the configurations in a fixed order and picks the first one whose partition counts hold enough lines for the requested vertical filter taps. The caller presents the picture geometry, the stored pixel depth, the alpha enable, the chroma subsampling flag, the luma and chroma vertical tap counts and the rounded-up vertical scale ratios, then pulses a start. All inputs are captured on that start.

For each candidate the unit works out how many 72-bit memory words one line takes for luma, chroma and alpha. It divides the memory size of the candidate by those line sizes with one shared multi-cycle restoring divider. It then applies the alpha limit and the cap, and checks the ratio-dependent validity rule. The result is the chosen configuration number together with its luma and chroma partition counts, and a one-cycle done strobe. An error flag is raised when even the fallback configuration cannot hold the taps. A debug input skips the search and returns the largest configuration at once.

Top module: `lb_cfg_search`

## Requirements
- R1: After reset, busy, done and error are low, and the configuration and both partition counts read zero.
- R2: The line length of a plane is the smaller of that plane's viewport width and the output width. A zero line length is replaced by 1. A line occupies ceil(length*bpc/72) words. The depth code sets bpc: 0 gives 10, 1 gives 8, 2 gives 6 and 3 gives 12.
- R3: The memory words per plane (luma/chroma/alpha) are: config 1 816/816/984, config 2 1088/1088/1312, config 3 3600/1904/2752, config 0 2752/2752/2752. The partition count of a plane is the memory words divided by the line words, rounded down, and is then capped at 64.
- R4: When alpha is enabled, the alpha line takes ceil(luma length/6) words. The luma count is lowered to the alpha partition count when that count is smaller.
- R5: Each plane must satisfy its own rule. If its ratio ceiling exceeds 2, taps + ratio <= partitions + 2 must hold; otherwise taps <= partitions must hold. A configuration is accepted only when both luma and chroma satisfy their rules.
- R6: Candidates are tried in the order 1, 2, 3, 0. Config 3 is tried only when the 4:2:0 flag is set, and config 0 is the final fallback.
- R7: When config 0 also fails R5, the result is config 0 with its own counts, and the error flag is high.
- R8: A start with the force input high gives done in the next cycle, with config 0, both counts zero and the error flag low.
- R9: Done is high for exactly one cycle. Busy is high during a search. The results hold their value until the next result is produced.
- R10: Inputs are captured on an accepted start. A start that arrives while busy is ignored.
- R11: A start in the same cycle as done is accepted and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a search |
| force_max_i | input | 1 | Debug: return config 0 immediately |
| vp_w_y_i | input | PIX_W | Luma viewport width |
| vp_w_c_i | input | PIX_W | Chroma viewport width |
| rec_w_i | input | PIX_W | Output rectangle width |
| depth_i | input | 2 | Stored pixel depth code |
| alpha_en_i | input | 1 | Alpha plane stored |
| is420_i | input | 1 | 4:2:0 input, enables config 3 |
| vtaps_y_i | input | TAP_W | Luma vertical taps |
| vtaps_c_i | input | TAP_W | Chroma vertical taps |
| cvr_y_i | input | RAT_W | Ceiling of luma vertical ratio |
| cvr_c_i | input | RAT_W | Ceiling of chroma vertical ratio |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| cfg_o | output | 2 | Chosen configuration number |
| part_y_o | output | PART_W | Luma partition count |
| part_c_o | output | PART_W | Chroma partition count |
| err_o | output | 1 | Fallback configuration also invalid |

## Verification
The completion of one search and the acceptance of the next can fall in the same cycle. The done strobe is registered while the unit is already idle, so a start that arrives in that cycle is taken. The bench waits for done, raises start with a different geometry in that same cycle, and expects the second result to match the new inputs rather than the old ones. A start that arrives in the middle of a search is the contrasting case: the bench expects it to change nothing, and the first result must come out unchanged.

// File: rtl/lb_cfg_pkg.sv
package lb_cfg_pkg;

    localparam int unsigned PART_CAP = 64;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DIV_Y = 3'd1,
        S_DIV_C = 3'd2,
        S_DIV_A = 3'd3,
        S_EVAL  = 3'd4
    } lb_state_e;

    // bits per component stored for a depth code
    function automatic logic [3:0] bpc_of(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd10;
            2'd1:    return 4'd8;
            2'd2:    return 4'd6;
            default: return 4'd12;
        endcase
    endfunction

    // search position to configuration number
    function automatic logic [1:0] cfg_at(input logic [1:0] pos);
        case (pos)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            2'd2:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    // memory words for a configuration and plane (0 luma, 1 chroma, 2 alpha)
    function automatic logic [11:0] mem_words(input logic [1:0] cfg, input logic [1:0] plane);
        case (cfg)
            2'd1: return (plane == 2'd2) ? 12'd984  : 12'd816;
            2'd2: return (plane == 2'd2) ? 12'd1312 : 12'd1088;
            2'd3: return (plane == 2'd0) ? 12'd3600 :
                         (plane == 2'd1) ? 12'd1904 : 12'd2752;
            default: return 12'd2752;
        endcase
    endfunction

    // enough lines for the taps at this ratio ceiling
    function automatic logic lb_fits(input logic [7:0] taps, input logic [7:0] cv,
                                     input logic [7:0] parts);
        if (cv > 8'd2)
            return ({1'b0, taps} + {1'b0, cv}) <= ({1'b0, parts} + 9'd2);
        else
            return taps <= parts;
    endfunction

endpackage

// File: rtl/lb_line_words.sv
module lb_line_words #(
    parameter int PIX_W = 13,
    parameter int OUT_W = PIX_W + 5
) (
    input  logic [PIX_W-1:0] vp_w_i,
    input  logic [PIX_W-1:0] rec_w_i,
    input  logic [1:0]       depth_i,
    output logic [OUT_W-1:0] words_o,
    output logic [OUT_W-1:0] alpha_words_o
);
    import lb_cfg_pkg::*;

    localparam int PW = PIX_W + 5;

    logic [PIX_W-1:0] len_min;
    logic [PIX_W-1:0] len;
    logic [PW-1:0]    sum_w;
    logic [PW-1:0]    sum_a;

    always_comb begin
        len_min = (vp_w_i < rec_w_i) ? vp_w_i : rec_w_i;
        len     = (len_min == '0) ? PIX_W'(1) : len_min;
        sum_w   = PW'(len) * PW'(bpc_of(depth_i)) + PW'(71);
        sum_a   = PW'(len) + PW'(5);
        words_o       = OUT_W'(sum_w / PW'(72));
        alpha_words_o = OUT_W'(sum_a / PW'(6));
    end

endmodule

// File: rtl/lb_rdiv.sv
module lb_rdiv #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic         fin_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
        logic [CW-1:0] cnt;
        logic          run;
        logic          fin;
    } div_t;

    div_t div_d, div_q;
    logic [W:0] trial;

    always_comb begin
        div_d     = div_q;
        div_d.fin = 1'b0;
        trial     = {div_q.rem, div_q.quo[W-1]};
        if (go_i) begin
            div_d.rem = '0;
            div_d.quo = num_i;
            div_d.den = den_i;
            div_d.cnt = CW'(W);
            div_d.run = 1'b1;
        end else if (div_q.run) begin
            if (trial >= {1'b0, div_q.den}) begin
                div_d.rem = W'(trial - {1'b0, div_q.den});
                div_d.quo = {div_q.quo[W-2:0], 1'b1};
            end else begin
                div_d.rem = W'(trial);
                div_d.quo = {div_q.quo[W-2:0], 1'b0};
            end
            div_d.cnt = div_q.cnt - CW'(1);
            if (div_q.cnt == CW'(1)) begin
                div_d.run = 1'b0;
                div_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign quo_o = div_q.quo;
    assign fin_o = div_q.fin;

endmodule

// File: rtl/lb_cfg_search.sv
module lb_cfg_search #(
    parameter int PIX_W  = 13,
    parameter int TAP_W  = 4,
    parameter int RAT_W  = 4,
    parameter int PART_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              force_max_i,
    input  logic [PIX_W-1:0]  vp_w_y_i,
    input  logic [PIX_W-1:0]  vp_w_c_i,
    input  logic [PIX_W-1:0]  rec_w_i,
    input  logic [1:0]        depth_i,
    input  logic              alpha_en_i,
    input  logic              is420_i,
    input  logic [TAP_W-1:0]  vtaps_y_i,
    input  logic [TAP_W-1:0]  vtaps_c_i,
    input  logic [RAT_W-1:0]  cvr_y_i,
    input  logic [RAT_W-1:0]  cvr_c_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        cfg_o,
    output logic [PART_W-1:0] part_y_o,
    output logic [PART_W-1:0] part_c_o,
    output logic              err_o
);
    import lb_cfg_pkg::*;

    localparam int DIV_W = PIX_W + 5;
    localparam int NPL   = 2;   // luma and chroma sizing lanes

    typedef struct packed {
        lb_state_e         st;
        logic [1:0]        pos;
        logic              issued;
        logic [PIX_W-1:0]  vpy;
        logic [PIX_W-1:0]  vpc;
        logic [PIX_W-1:0]  rec;
        logic [1:0]        dep;
        logic              al;
        logic              y420;
        logic [TAP_W-1:0]  vty;
        logic [TAP_W-1:0]  vtc;
        logic [RAT_W-1:0]  cvy;
        logic [RAT_W-1:0]  cvc;
        logic [DIV_W-1:0]  qy;
        logic [DIV_W-1:0]  qc;
        logic [DIV_W-1:0]  qa;
        logic              busy;
        logic              done;
        logic [1:0]        cfg;
        logic [PART_W-1:0] py;
        logic [PART_W-1:0] pc;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // line sizing, one lane per plane
    logic [DIV_W-1:0] lane_words [NPL];
    logic [DIV_W-1:0] lane_alpha [NPL];
    logic [PIX_W-1:0] lane_vp    [NPL];

    assign lane_vp[0] = ctl_q.vpy;
    assign lane_vp[1] = ctl_q.vpc;

    for (genvar g = 0; g < NPL; g++) begin : g_lane
        lb_line_words #(.PIX_W(PIX_W), .OUT_W(DIV_W)) u_lw (
            .vp_w_i        (lane_vp[g]),
            .rec_w_i       (ctl_q.rec),
            .depth_i       (ctl_q.dep),
            .words_o       (lane_words[g]),
            .alpha_words_o (lane_alpha[g])
        );
    end

    // shared divider
    logic             div_go;
    logic [DIV_W-1:0] div_num;
    logic [DIV_W-1:0] div_den;
    logic [DIV_W-1:0] div_quo;
    logic             div_fin;
    logic [1:0]       plane;
    logic [1:0]       cur_cfg;

    lb_rdiv #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (div_go),
        .num_i (div_num),
        .den_i (div_den),
        .quo_o (div_quo),
        .fin_o (div_fin)
    );

    always_comb begin
        cur_cfg = cfg_at(ctl_q.pos);
        case (ctl_q.st)
            S_DIV_C: plane = 2'd1;
            S_DIV_A: plane = 2'd2;
            default: plane = 2'd0;
        endcase
        div_num = DIV_W'(mem_words(cur_cfg, plane));
        case (plane)
            2'd1:    div_den = lane_words[1];
            2'd2:    div_den = lane_alpha[0];
            default: div_den = lane_words[0];
        endcase
    end

    // evaluation of the current candidate
    logic [DIV_W-1:0]  y_lim;
    logic [PART_W-1:0] py_cap;
    logic [PART_W-1:0] pc_cap;
    logic              cand_ok;

    always_comb begin
        y_lim  = (ctl_q.al && (ctl_q.qa < ctl_q.qy)) ? ctl_q.qa : ctl_q.qy;
        py_cap = (y_lim    > DIV_W'(PART_CAP)) ? PART_W'(PART_CAP) : PART_W'(y_lim);
        pc_cap = (ctl_q.qc > DIV_W'(PART_CAP)) ? PART_W'(PART_CAP) : PART_W'(ctl_q.qc);
        cand_ok = lb_fits(8'(ctl_q.vty), 8'(ctl_q.cvy), 8'(py_cap)) &&
                  lb_fits(8'(ctl_q.vtc), 8'(ctl_q.cvc), 8'(pc_cap));
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        div_go     = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (start_i) begin
                    ctl_d.vpy  = vp_w_y_i;
                    ctl_d.vpc  = vp_w_c_i;
                    ctl_d.rec  = rec_w_i;
                    ctl_d.dep  = depth_i;
                    ctl_d.al   = alpha_en_i;
                    ctl_d.y420 = is420_i;
                    ctl_d.vty  = vtaps_y_i;
                    ctl_d.vtc  = vtaps_c_i;
                    ctl_d.cvy  = cvr_y_i;
                    ctl_d.cvc  = cvr_c_i;
                    if (force_max_i) begin
                        ctl_d.done = 1'b1;
                        ctl_d.cfg  = 2'd0;
                        ctl_d.py   = '0;
                        ctl_d.pc   = '0;
                        ctl_d.err  = 1'b0;
                    end else begin
                        ctl_d.st     = S_DIV_Y;
                        ctl_d.pos    = 2'd0;
                        ctl_d.issued = 1'b0;
                        ctl_d.busy   = 1'b1;
                    end
                end
            end
            S_DIV_Y, S_DIV_C, S_DIV_A: begin
                if (!ctl_q.issued) begin
                    div_go       = 1'b1;
                    ctl_d.issued = 1'b1;
                end else if (div_fin) begin
                    ctl_d.issued = 1'b0;
                    case (ctl_q.st)
                        S_DIV_Y: begin ctl_d.qy = div_quo; ctl_d.st = S_DIV_C; end
                        S_DIV_C: begin ctl_d.qc = div_quo; ctl_d.st = S_DIV_A; end
                        default: begin ctl_d.qa = div_quo; ctl_d.st = S_EVAL;  end
                    endcase
                end
            end
            S_EVAL: begin
                if (cand_ok || ctl_q.pos == 2'd3) begin
                    ctl_d.st   = S_IDLE;
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.cfg  = cur_cfg;
                    ctl_d.py   = py_cap;
                    ctl_d.pc   = pc_cap;
                    ctl_d.err  = !cand_ok;
                end else begin
                    ctl_d.st = S_DIV_Y;
                    if (ctl_q.pos == 2'd1 && !ctl_q.y420) ctl_d.pos = 2'd3;
                    else                                  ctl_d.pos = ctl_q.pos + 2'd1;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy_o   = ctl_q.busy;
    assign done_o   = ctl_q.done;
    assign cfg_o    = ctl_q.cfg;
    assign part_y_o = ctl_q.py;
    assign part_c_o = ctl_q.pc;
    assign err_o    = ctl_q.err;

endmodule

// File: rtl/lb_cfg_search_chk.sv
module lb_cfg_search_chk #(
    parameter int PART_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              force_max_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        cfg_o,
    input logic [PART_W-1:0] part_y_o,
    input logic [PART_W-1:0] part_c_o,
    input logic              err_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(cfg_o) && $stable(part_y_o) && $stable(part_c_o) && $stable(err_o))); // R9
    AST_PART_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (part_y_o <= PART_W'(64)) && (part_c_o <= PART_W'(64))); // R3
    AST_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cfg_o == 2'd0)); // R7
    AST_FORCE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && force_max_i) |=> (done_o && cfg_o == 2'd0 && part_y_o == '0 && !err_o)); // R8
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !force_max_i) |=> (busy_o && !done_o)); // R11
endmodule

bind lb_cfg_search lb_cfg_search_chk #(.PART_W(PART_W)) u_chk (.*);

// File: tb/sim_lb_cfg_search.sv
module sim_lb_cfg_search;

    typedef struct packed {
        logic [12:0] vpy;
        logic [12:0] vpc;
        logic [12:0] rec;
        logic [1:0]  dep;
        logic        al;
        logic        y420;
        logic [3:0]  vty;
        logic [3:0]  vtc;
        logic [3:0]  cvy;
        logic [3:0]  cvc;
        logic [1:0]  ecfg;
        logic [6:0]  epy;
        logic [6:0]  epc;
        logic        eerr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TAB [NV] = '{
        '{13'd1920, 13'd960,  13'd1920, 2'd1, 1'b0, 1'b0, 4'd4,  4'd4,  4'd1, 4'd1, 2'd2, 7'd5,  7'd10, 1'b0}, // R6 cfg1 short
        '{13'd640,  13'd320,  13'd1280, 2'd0, 1'b0, 1'b0, 4'd4,  4'd4,  4'd1, 4'd1, 2'd1, 7'd9,  7'd18, 1'b0}, // R2 10bpc
        '{13'd3840, 13'd1920, 13'd3840, 2'd1, 1'b1, 1'b0, 4'd2,  4'd2,  4'd1, 4'd1, 2'd2, 7'd2,  7'd5,  1'b0}, // R4 alpha not limiting
        '{13'd3840, 13'd1920, 13'd3840, 2'd3, 1'b1, 1'b1, 4'd4,  4'd2,  4'd1, 4'd1, 2'd3, 7'd4,  7'd5,  1'b0}, // R4 alpha limits, R6 cfg3
        '{13'd3840, 13'd1920, 13'd3840, 2'd3, 1'b1, 1'b0, 4'd4,  4'd2,  4'd1, 4'd1, 2'd0, 7'd4,  7'd8,  1'b0}, // R6 cfg3 skipped
        '{13'd640,  13'd320,  13'd1280, 2'd0, 1'b0, 1'b0, 4'd4,  4'd4,  4'd8, 4'd1, 2'd2, 7'd12, 7'd24, 1'b0}, // R5 large ratio
        '{13'd640,  13'd320,  13'd1280, 2'd0, 1'b0, 1'b0, 4'd9,  4'd4,  4'd2, 4'd1, 2'd1, 7'd9,  7'd18, 1'b0}, // R5 ratio 2 plain rule
        '{13'd640,  13'd320,  13'd1280, 2'd0, 1'b0, 1'b0, 4'd8,  4'd4,  4'd3, 4'd1, 2'd1, 7'd9,  7'd18, 1'b0}, // R5 boundary fits
        '{13'd640,  13'd320,  13'd1280, 2'd0, 1'b0, 1'b0, 4'd9,  4'd4,  4'd3, 4'd1, 2'd2, 7'd12, 7'd24, 1'b0}, // R5 boundary misses
        '{13'd0,    13'd0,    13'd100,  2'd1, 1'b0, 1'b0, 4'd8,  4'd8,  4'd1, 4'd1, 2'd1, 7'd64, 7'd64, 1'b0}, // R3 zero width, cap
        '{13'd3840, 13'd1920, 13'd3840, 2'd3, 1'b1, 1'b0, 4'd15, 4'd2,  4'd1, 4'd1, 2'd0, 7'd4,  7'd8,  1'b1}, // R7 fallback fails
        '{13'd1920, 13'd1920, 13'd1000, 2'd2, 1'b0, 1'b0, 4'd4,  4'd4,  4'd1, 4'd1, 2'd1, 7'd9,  7'd9,  1'b0}, // R2 6bpc, output width
        '{13'd640,  13'd320,  13'd1280, 2'd0, 1'b0, 1'b0, 4'd4,  4'd12, 4'd1, 4'd8, 2'd1, 7'd9,  7'd18, 1'b0}  // R5 chroma boundary
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        force_max_i = 1'b0;
    logic [12:0] vp_w_y_i = '0, vp_w_c_i = '0, rec_w_i = '0;
    logic [1:0]  depth_i = '0;
    logic        alpha_en_i = 1'b0, is420_i = 1'b0;
    logic [3:0]  vtaps_y_i = '0, vtaps_c_i = '0, cvr_y_i = '0, cvr_c_i = '0;
    logic        busy_o, done_o, err_o;
    logic [1:0]  cfg_o;
    logic [6:0]  part_y_o, part_c_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    lb_cfg_search u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic apply(input vec_t v, input logic frc);
        vp_w_y_i = v.vpy; vp_w_c_i = v.vpc; rec_w_i = v.rec;
        depth_i = v.dep; alpha_en_i = v.al; is420_i = v.y420;
        vtaps_y_i = v.vty; vtaps_c_i = v.vtc; cvr_y_i = v.cvy; cvr_c_i = v.cvc;
        force_max_i = frc;
    endtask

    task automatic pulse_start(input vec_t v, input logic frc);
        apply(v, frc);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        force_max_i = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (!done_o) check("R9 done timeout", 0, 1);
    endtask

    task automatic check_res(input string req, input vec_t v);
        check({req, " cfg"}, cfg_o, v.ecfg);
        check({req, " part_y"}, part_y_o, v.epy);
        check({req, " part_c"}, part_c_o, v.epc);
        check({req, " err"}, err_o, v.eerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 cfg", cfg_o, 0);
        check("R1 part_y", part_y_o, 0);
        check("R1 part_c", part_c_o, 0);
        check("R1 err", err_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            pulse_start(TAB[i], 1'b0);
            check("R9 busy during search", busy_o, 1);
            wait_done();
            check_res($sformatf("table[%0d]", i), TAB[i]);
            @(negedge clk);
            check("R9 done single cycle", done_o, 0);
        end

        // R8 forced largest buffer
        pulse_start(TAB[0], 1'b1);
        check("R8 done next cycle", done_o, 1);
        check("R8 cfg", cfg_o, 0);
        check("R8 part_y", part_y_o, 0);
        check("R8 part_c", part_c_o, 0);
        check("R8 err", err_o, 0);

        // R10 start during search ignored, inputs captured at start
        @(negedge clk);
        pulse_start(TAB[1], 1'b0);
        repeat (5) @(negedge clk);
        pulse_start(TAB[0], 1'b0);
        apply(TAB[10], 1'b0);
        wait_done();
        check_res("R10 mid-search start", TAB[1]);
        repeat (4) @(negedge clk);
        check("R9 result held cfg", cfg_o, TAB[1].ecfg);
        check("R9 result held part_c", part_c_o, TAB[1].epc);

        // R11 start in the done cycle
        pulse_start(TAB[1], 1'b0);
        wait_done();
        check_res("R11 first", TAB[1]);
        pulse_start(TAB[0], 1'b0);
        check("R11 accepted busy", busy_o, 1);
        wait_done();
        check_res("R11 second", TAB[0]);

        finish_run();
    end

endmodule